// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a bank of asynchronous digital inputs and raises a single interrupt request when a programmed pattern appears on them. Each input channel has two select bits. One lives in a "high" mask and the other in a "low" mask. A control register chooses between two ways of combining them. In edge mode, any selected transition on any channel fires. In level mode, the event fires only when every selected channel sits at its chosen level at the same moment.

When an event fires, the controller records which channels took part in a sticky status register. It then holds its request line high until the host reads that register, and the read clears it. Level mode disarms itself after each event. It rearms only once a selected input changes level, so a static pattern cannot flood the host.

The host reaches the block through a small four-word register bus. There is one write strobe, one read strobe, and a combinational read-data path.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0 and all four registers (high mask at address 0, low mask at address 1, control at address 2, status at address 3) read 0.
- R2: The high mask, the low mask and the control word (bit 0 enable, bit 1 combine mode: 0 = edge, 1 = level) read back what was written; control bits above bit 1 read 0.
- R3: In edge mode with enable set, a rising input on a channel whose high-mask bit is set makes `irq_o` go high on the third rising clock edge after the input changes, and sets that channel's status bit.
- R4: In edge mode a falling input fires on channels whose low-mask bit is set; a channel set in both masks fires on either direction.
- R5: In level mode the event fires only when every channel set in either mask is at its selected level (high mask: 1, low mask: 0) at the same time; the status then holds exactly the selected channels.
- R6: After a level-mode event, no new event fires while the pattern stays met. A level change on a selected channel rearms the logic, and when the pattern is next met, a new event fires.
- R7: In level mode, a channel set in both masks can never be satisfied, so no event ever fires.
- R8: A read of the status address returns the captured channels, then clears the status and drops `irq_o`. Events that arrive while a request is pending are ORed into the status.
- R9: With enable clear, no new event is captured, and the pending status and request are held. Clearing and setting enable around the status read neither loses the pending event nor causes a second event for an unchanged level pattern.
- R10: Writing zero to both masks and the control word, then reading status, leaves the block idle: status 0, `irq_o` 0, and input activity raises nothing.
- R11: Channels selected in neither mask never appear in status and never cause an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | NUM_CH | Asynchronous channel inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a status read clears) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | NUM_CH | Write data |
| bus_rdata | output | NUM_CH | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Interrupt request, held until the status read |

## Verification
A corrupted mask or mode bit shows up at the ports within three clock edges of the next input transition. It appears either as a request that should not rise or as a status word with wrong channel bits. A stuck arming flag in level mode shows up as a missing second event after a rearming level change, or as an extra event during a static pattern. Status that is cleared too early or merged too late shows up on the very next status read, as a dropped or extra channel bit.

// File: rtl/cos_pkg.sv
package cos_pkg;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_MASK_HI = 2'd0;
   localparam logic [ADDR_W-1:0] A_MASK_LO = 2'd1;
   localparam logic [ADDR_W-1:0] A_CTRL    = 2'd2;
   localparam logic [ADDR_W-1:0] A_STATUS  = 2'd3;

   typedef enum logic {
      CMB_EDGE  = 1'b0,
      CMB_LEVEL = 1'b1
   } combine_e;

   typedef struct packed {
      combine_e mode;    // bit 1
      logic     enable;  // bit 0
   } ctrl_t;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cos_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;
   logic [W-1:0]             prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= '0;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign cur_o  = chain_q[STAGES-1];
   assign prev_o = prev_q;
endmodule

// File: rtl/cos_detect.sv
module cos_detect #(
   parameter int W = 16
) (
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] prev_i,
   input  logic [W-1:0] mask_hi_i,
   input  logic [W-1:0] mask_lo_i,
   output logic [W-1:0] edge_hit_o,
   output logic [W-1:0] lvl_ok_o,
   output logic [W-1:0] changed_o
);
   for (genvar c = 0; c < W; c++) begin : g_ch
      logic rise, fall;
      assign rise          = cur_i[c] & ~prev_i[c];
      assign fall          = ~cur_i[c] & prev_i[c];
      assign edge_hit_o[c] = (rise & mask_hi_i[c]) | (fall & mask_lo_i[c]);
      // unselected channels are neutral in the AND; both-selected never holds
      assign lvl_ok_o[c]   = (~mask_hi_i[c] | cur_i[c]) & (~mask_lo_i[c] | ~cur_i[c]);
      assign changed_o[c]  = rise | fall;
   end
endmodule

// File: rtl/cos_capture.sv
module cos_capture #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable_i,
   input  logic         level_mode_i,
   input  logic [W-1:0] sel_i,
   input  logic [W-1:0] edge_hit_i,
   input  logic [W-1:0] lvl_ok_i,
   input  logic [W-1:0] changed_i,
   input  logic         rearm_i,
   input  logic         clr_i,
   output logic [W-1:0] status_o,
   output logic         irq_o
);
   logic [W-1:0] status_q;
   logic         irq_q;
   logic         armed_q;
   logic         pattern_met;
   logic         fire_edge, fire_level;
   logic [W-1:0] new_ev;

   assign pattern_met = (|sel_i) && (&lvl_ok_i);
   assign fire_edge   = enable_i && !level_mode_i && (|edge_hit_i);
   assign fire_level  = enable_i && level_mode_i && armed_q && pattern_met;

   always_comb begin
      new_ev = '0;
      if (fire_edge)       new_ev = edge_hit_i;
      else if (fire_level) new_ev = sel_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         status_q <= (clr_i ? '0 : status_q) | new_ev;
         irq_q    <= (clr_i ? 1'b0 : irq_q) | (|new_ev);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       armed_q <= 1'b1;
      else if (rearm_i)                 armed_q <= 1'b1;
      else if (fire_level)              armed_q <= 1'b0;
      else if (|(changed_i & sel_i))    armed_q <= 1'b1;
   end

   assign status_o = status_q;
   assign irq_o    = irq_q;

   p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable_i && !clr_i) |=> $stable(status_q));

   p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !enable_i) |=> (status_q == '0 && !irq_q));

   p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr_i) |=> irq_q);

   p_level_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && level_mode_i && armed_q && pattern_met && !rearm_i) |=> !armed_q);

   p_edge_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && !level_mode_i && (|edge_hit_i)) |=> irq_q);
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
   import cos_pkg::*;
#(
   parameter int NUM_CH      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] din,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NUM_CH-1:0] bus_wdata,
   output logic [NUM_CH-1:0] bus_rdata,
   output logic              irq_o
);
   localparam int CTRL_W = $bits(ctrl_t);

   if (NUM_CH < CTRL_W) begin : g_bad_width
      $error("cos_irq_ctrl: NUM_CH must hold the control word");
   end

   logic [NUM_CH-1:0] mask_hi_q, mask_lo_q;
   ctrl_t             ctrl_q;
   ctrl_t             ctrl_wr;
   logic              rearm, clr;
   logic [NUM_CH-1:0] cur, prev, edge_hit, lvl_ok, changed, status;
   logic              unused_wbits;

   assign ctrl_wr      = ctrl_t'(bus_wdata[CTRL_W-1:0]);
   assign unused_wbits = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_hi_q <= '0;
         mask_lo_q <= '0;
         ctrl_q    <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            A_MASK_HI: mask_hi_q <= bus_wdata;
            A_MASK_LO: mask_lo_q <= bus_wdata;
            A_CTRL:    ctrl_q    <= ctrl_wr;
            default:   ;
         endcase
      end
   end

   // a new selection or combine mode starts armed; enable toggles keep arming state
   assign rearm = bus_wr && ((bus_addr == A_MASK_HI) || (bus_addr == A_MASK_LO) ||
                  ((bus_addr == A_CTRL) && (ctrl_wr.mode != ctrl_q.mode)));
   assign clr   = bus_rd && (bus_addr == A_STATUS);

   always_comb begin
      case (bus_addr)
         A_MASK_HI: bus_rdata = mask_hi_q;
         A_MASK_LO: bus_rdata = mask_lo_q;
         A_CTRL:    bus_rdata = {{(NUM_CH-CTRL_W){1'b0}}, ctrl_q};
         default:   bus_rdata = status;
      endcase
   end

   cos_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (din),
      .cur_o   (cur),
      .prev_o  (prev)
   );

   cos_detect #(.W(NUM_CH)) u_detect (
      .cur_i      (cur),
      .prev_i     (prev),
      .mask_hi_i  (mask_hi_q),
      .mask_lo_i  (mask_lo_q),
      .edge_hit_o (edge_hit),
      .lvl_ok_o   (lvl_ok),
      .changed_o  (changed)
   );

   cos_capture #(.W(NUM_CH)) u_capture (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable_i     (ctrl_q.enable),
      .level_mode_i (ctrl_q.mode == CMB_LEVEL),
      .sel_i        (mask_hi_q | mask_lo_q),
      .edge_hit_i   (edge_hit),
      .lvl_ok_i     (lvl_ok),
      .changed_i    (changed),
      .rearm_i      (rearm),
      .clr_i        (clr),
      .status_o     (status),
      .irq_o        (irq_o)
   );

   p_unselected_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status) & ~(mask_hi_q | mask_lo_q)) == '0) || $past(bus_wr));
endmodule

// File: tb/cos_irq_ctrl_tb_top.sv
module cos_irq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] din = '0;
   logic         bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]   bus_addr = '0;
   logic [N-1:0] bus_wdata = '0;
   logic [N-1:0] bus_rdata;
   logic         irq_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cos_irq_ctrl #(.NUM_CH(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .din(din), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_din(input logic [N-1:0] v);
      @(negedge clk);
      din = v;
   endtask

   // quiesce: disable, inputs low, flush status
   task automatic idle_all();
      logic [N-1:0] junk;
      wr(2'd2, '0);
      set_din('0);
      settle(5);
      rd(2'd3, junk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [N-1:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", irq_o, 0);
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], r);
         check("R1 reg", r, 0);
      end

      // R2 readback
      wr(2'd0, 16'hA5C3); rd(2'd0, r); check("R2 mask_hi", r, 16'hA5C3);
      wr(2'd1, 16'h3C5A); rd(2'd1, r); check("R2 mask_lo", r, 16'h3C5A);
      wr(2'd2, 16'hFFFE); rd(2'd2, r); check("R2 ctrl", r, 16'h0002);
      idle_all();

      // R3 R4 R11 edge-mode sweep over every channel and mask pattern
      for (int ch = 0; ch < N; ch++) begin
         for (int m = 1; m < 4; m++) begin
            logic [N-1:0] bit_c, nb;
            bit_c = N'(1) << ch;
            nb    = N'(1) << ((ch + 1) % N);
            idle_all();
            wr(2'd0, m[0] ? bit_c : '0);
            wr(2'd1, m[1] ? bit_c : '0);
            wr(2'd2, 16'h0001);
            set_din(bit_c | nb);
            @(posedge clk); @(posedge clk); #1;
            check("R3 irq not before third edge", irq_o, 0);
            @(posedge clk); #1;
            check("R3 rise irq", irq_o, m[0]);
            settle(2);
            rd(2'd3, r);
            check("R3 R11 rise status", r, m[0] ? bit_c : '0);
            #1 check("R8 irq after read", irq_o, 0);
            set_din('0);
            settle(5);
            check("R4 fall irq", irq_o, m[1]);
            rd(2'd3, r);
            check("R4 R11 fall status", r, m[1] ? bit_c : '0);
         end
      end

      // R8 events ORed while pending
      idle_all();
      wr(2'd0, 16'h0003); wr(2'd1, 16'h0000); wr(2'd2, 16'h0001);
      set_din(16'h0001); settle(5);
      set_din(16'h0003); settle(5);
      check("R8 irq pending", irq_o, 1);
      rd(2'd3, r); check("R8 merged status", r, 16'h0003);
      settle(2); check("R8 irq cleared", irq_o, 0);

      // R5 R6 level-mode sweep
      for (int ch = 0; ch < N; ch++) begin
         logic [N-1:0] hb, lb;
         hb = N'(1) << ch;
         lb = N'(1) << ((ch + 3) % N);
         idle_all();
         wr(2'd0, hb); wr(2'd1, lb); wr(2'd2, 16'h0003);
         settle(5);
         check("R5 partial pattern no irq", irq_o, 0);
         set_din(hb | lb);  // low-selected channel not low
         settle(5);
         check("R5 low channel high no irq", irq_o, 0);
         set_din(hb);
         settle(5);
         check("R5 pattern met irq", irq_o, 1);
         rd(2'd3, r);
         check("R5 status = selected", r, hb | lb);
         settle(6);
         check("R6 no refire while met", irq_o, 0);
         set_din(hb | (N'(1) << ((ch + 7) % N)));  // unselected change
         settle(6);
         check("R6 unselected change no rearm", irq_o, 0);
         set_din('0); settle(5);
         check("R6 broken pattern no irq", irq_o, 0);
         set_din(hb); settle(5);
         check("R6 rearm refire", irq_o, 1);
         rd(2'd3, r);
         check("R6 refire status", r, hb | lb);
      end

      // R7 both masks in level mode never fire
      idle_all();
      wr(2'd0, 16'h0010); wr(2'd1, 16'h0010); wr(2'd2, 16'h0003);
      set_din(16'h0010); settle(5);
      set_din(16'h0000); settle(5);
      set_din(16'h0010); settle(5);
      check("R7 no irq", irq_o, 0);
      rd(2'd3, r); check("R7 status", r, 0);

      // R9 enable toggle around read in level mode
      idle_all();
      wr(2'd0, 16'h0003); wr(2'd1, 16'h0004); wr(2'd2, 16'h0003);
      set_din(16'h0003); settle(5);
      check("R9 pending irq", irq_o, 1);
      wr(2'd2, 16'h0002);
      check("R9 irq held while disabled", irq_o, 1);
      rd(2'd3, r); check("R9 status not lost", r, 16'h0007);
      wr(2'd2, 16'h0003); settle(6);
      check("R9 no duplicate", irq_o, 0);

      // R9 edge mode: edges while disabled are not captured
      idle_all();
      wr(2'd0, 16'h0100); wr(2'd1, 16'h0000);
      set_din(16'h0100); settle(5);
      wr(2'd2, 16'h0001); settle(5);
      check("R9 disabled edge dropped", irq_o, 0);
      rd(2'd3, r); check("R9 disabled status", r, 0);

      // R10 idle sequence
      wr(2'd0, 16'hFFFF); wr(2'd1, 16'hFFFF); wr(2'd2, 16'h0001);
      set_din(16'h0000); settle(5);
      wr(2'd0, '0); wr(2'd1, '0); wr(2'd2, '0);
      rd(2'd3, r);
      settle(2);
      check("R10 irq idle", irq_o, 0);
      set_din(16'hFFFF); settle(5); set_din(16'h0000); settle(5);
      check("R10 irq after activity", irq_o, 0);
      rd(2'd3, r); check("R10 status", r, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule